// File: doc/BRIEF.md
# Universal Storage Bus Transceiver

A seventeen-bit bidirectional channel group. It connects a local A side, which has separate input and output buses, with a shared B bus that is open-drain. The group is split into a wide section (bits 8:0) and a narrow section (bits 16:9). Each section has its own enable pairs, pass controls and capture clocks.

Each direction of each section has a storage cell with three modes:

- **Transparent:** the pass control is high and the cell follows its input.
- **Capture:** the pass control is low and a rising edge of the direction's tick input loads the cell.
- **Hold:** the pass control is low and no rising edge arrives, so the cell keeps its value.

Tick inputs are sampled by the system clock, and a rise is seen as a low-to-high change between two samples. When the B bus is enabled, a stored 1 sinks the line low and a stored 0 releases it. The A outputs carry the bitwise inverse of the B-to-A path.

A clock line from the B side is forwarded unchanged to an A-side clock output. It is used by the narrow section's far-end partner.

Top module: `univ_store_xcvr`

## Requirements
- R1: `b_sink` (1 = pull the line low) is nonzero only where the section's `b_en_h` is 1 and its `b_en_l` is 0. Every other combination gives 0 on all of that section's bits.
- R2: `a_drive[s]` is 1 exactly when `a_en_h[s]` is 1 and `a_en_l[s]` is 0.
- R3: `a_out` is always the bitwise inverse of the value of the B-to-A path.
- R4: When the B bus is enabled, each `b_sink` bit equals the value of the A-to-B path for that bit. A stored 1 therefore reads as a low line.
- R5: While a pass control is 1, its path follows its input in the same cycle, whatever its tick input does.
- R6: While a pass control is 0, a tick sampled high after being sampled low loads the input present at that clock edge. The new value is visible after that edge.
- R7: While a pass control is 0 and no tick rise occurs, the path keeps its value. This holds while the tick stays high. A pass control that drops keeps the value it passed at the last clock edge.
- R8: Both directions run independently and may capture in the same cycle. A-to-B captures `a_in`, and B-to-A captures the line as it is resolved before that edge.
- R9: Control bit 0 governs bits 8:0 and control bit 1 governs bits 16:9. Neither section reacts to the other's controls.
- R10: `fwd_clk_a` equals `fwd_clk_b` combinationally.
- R11: Synchronous reset clears every cell to 0 and records each tick as already high. A tick that is high when reset is released does not capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 17 | A-side input bus |
| a_out | output | 17 | A-side output data (inverted B-to-A path) |
| a_drive | output | 2 | A output enable per section |
| b_in | input | 17 | Resolved B line levels |
| b_sink | output | 17 | Open-drain pull-down per B line |
| b_en_h | input | 2 | B enable, active high, per section |
| b_en_l | input | 2 | B enable, active low, per section |
| a_en_h | input | 2 | A enable, active high, per section |
| a_en_l | input | 2 | A enable, active low, per section |
| ab_pass | input | 2 | A-to-B transparent control per section |
| ab_tick | input | 2 | A-to-B capture clock per section |
| ba_pass | input | 2 | B-to-A transparent control per section |
| ba_tick | input | 2 | B-to-A capture clock per section |
| fwd_clk_b | input | 1 | B-side clock line |
| fwd_clk_a | output | 1 | Forwarded A-side clock |

## Verification
The two functions that can fall in the same cycle are the A-to-B capture and the B-to-A capture of one section. Both ticks are raised in one cycle, and the B-to-A cell samples a line that the A-to-B cell is about to change. The bench models a pull-up plus external pull-downs, so it resolves the line from `b_sink` and its own sinks. It then expects the B-to-A capture to see the pre-edge sink value, while `b_sink` shows the newly captured A data.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic on;
    logic en_n;
  } en_pair_t;

  function automatic logic pair_live(input en_pair_t p);
    return p.on & ~p.en_n;
  endfunction
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pass,
  input  logic         tick,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic         tick_q;
  logic         cap_rise;
  logic [W-1:0] held;

  assign cap_rise = tick & ~tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= 1'b1;
      held   <= '0;
    end else begin
      tick_q <= tick;
      if (pass || cap_rise) held <= d;
    end
  end

  assign q = pass ? d : held;

  assert_follow_R5: assert property (@(posedge clk) disable iff (rst)
    pass |=> (held == $past(d)));
  assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
    (!pass && cap_rise) |=> (held == $past(d)));
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!pass && !cap_rise) |=> $stable(held));
endmodule

// File: rtl/xcvr_section.sv
module xcvr_section
  import xcvr_pkg::*;
#(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drive,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_sink,
  input  logic         b_en_h,
  input  logic         b_en_l,
  input  logic         a_en_h,
  input  logic         a_en_l,
  input  logic         ab_pass,
  input  logic         ab_tick,
  input  logic         ba_pass,
  input  logic         ba_tick
);
  en_pair_t     b_pair;
  en_pair_t     a_pair;
  logic         b_live;
  logic [W-1:0] ab_q;
  logic [W-1:0] ba_q;

  assign b_pair = '{on: b_en_h, en_n: b_en_l};
  assign a_pair = '{on: a_en_h, en_n: a_en_l};
  assign b_live = pair_live(b_pair);

  xcvr_store #(.W(W)) u_ab (
    .clk (clk), .rst (rst), .pass (ab_pass), .tick (ab_tick),
    .d   (a_in), .q (ab_q)
  );

  xcvr_store #(.W(W)) u_ba (
    .clk (clk), .rst (rst), .pass (ba_pass), .tick (ba_tick),
    .d   (b_in), .q (ba_q)
  );

  assign b_sink  = b_live ? ab_q : '0;
  assign a_drive = pair_live(a_pair);
  assign a_out   = ~ba_q;

  assert_b_isolate_R1: assert property (@(posedge clk) disable iff (rst)
    !(b_en_h && !b_en_l) |-> (b_sink == '0));
  assert_a_enable_R2: assert property (@(posedge clk) disable iff (rst)
    a_drive |-> (a_en_h && !a_en_l));
endmodule

// File: rtl/xcvr_clkfwd.sv
module xcvr_clkfwd (
  input  logic src,
  output logic dst
);
  assign dst = src;
endmodule

// File: rtl/univ_store_xcvr.sv
module univ_store_xcvr #(
  parameter int WIDE_W   = 9,
  parameter int NARROW_W = 8,
  localparam int TOT_W   = WIDE_W + NARROW_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TOT_W-1:0] a_in,
  output logic [TOT_W-1:0] a_out,
  output logic [1:0]       a_drive,
  input  logic [TOT_W-1:0] b_in,
  output logic [TOT_W-1:0] b_sink,
  input  logic [1:0]       b_en_h,
  input  logic [1:0]       b_en_l,
  input  logic [1:0]       a_en_h,
  input  logic [1:0]       a_en_l,
  input  logic [1:0]       ab_pass,
  input  logic [1:0]       ab_tick,
  input  logic [1:0]       ba_pass,
  input  logic [1:0]       ba_tick,
  input  logic             fwd_clk_b,
  output logic             fwd_clk_a
);
  for (genvar s = 0; s < 2; s++) begin : g_sec
    localparam int W   = (s == 0) ? WIDE_W : NARROW_W;
    localparam int OFF = (s == 0) ? 0 : WIDE_W;

    xcvr_section #(.W(W)) u_sec (
      .clk     (clk),
      .rst     (rst),
      .a_in    (a_in[OFF +: W]),
      .a_out   (a_out[OFF +: W]),
      .a_drive (a_drive[s]),
      .b_in    (b_in[OFF +: W]),
      .b_sink  (b_sink[OFF +: W]),
      .b_en_h  (b_en_h[s]),
      .b_en_l  (b_en_l[s]),
      .a_en_h  (a_en_h[s]),
      .a_en_l  (a_en_l[s]),
      .ab_pass (ab_pass[s]),
      .ab_tick (ab_tick[s]),
      .ba_pass (ba_pass[s]),
      .ba_tick (ba_tick[s])
    );
  end

  xcvr_clkfwd u_fwd (.src(fwd_clk_b), .dst(fwd_clk_a));
endmodule

// File: tb/univ_store_xcvr_test.sv
module univ_store_xcvr_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [16:0] a_in = '0, a_out, b_sink, ext_low = '0, b_line;
  logic [1:0]  a_drive;
  logic [1:0]  b_en_h = '0, b_en_l = '0, a_en_h = '0, a_en_l = '0;
  logic [1:0]  ab_pass = '0, ab_tick = '0, ba_pass = '0, ba_tick = '0;
  logic        fwd_clk_b = 1'b0, fwd_clk_a;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // pull-up per line, wired with design and external sinks
  assign b_line = ~(b_sink | ext_low);

  univ_store_xcvr uut (
    .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
    .b_in(b_line), .b_sink(b_sink), .b_en_h(b_en_h), .b_en_l(b_en_l),
    .a_en_h(a_en_h), .a_en_l(a_en_l), .ab_pass(ab_pass), .ab_tick(ab_tick),
    .ba_pass(ba_pass), .ba_tick(ba_tick), .fwd_clk_b(fwd_clk_b), .fwd_clk_a(fwd_clk_a)
  );

  // {b_en_h, b_en_l, a_en_h, a_en_l, a_in, ext_low}
  localparam logic [41:0] VEC [8] = '{
    {8'b11_00_11_00, 17'h1A5C3, 17'h00011},
    {8'b00_00_00_00, 17'h0FFFF, 17'h10200},
    {8'b11_11_11_11, 17'h13579, 17'h0000F},
    {8'b01_10_10_01, 17'h1FFFF, 17'h00000},
    {8'b10_01_01_10, 17'h1FFFF, 17'h00300},
    {8'b11_01_10_00, 17'h0C0FE, 17'h18001},
    {8'b10_00_11_10, 17'h155AA, 17'h02000},
    {8'b01_01_01_01, 17'h1E1E1, 17'h00C00}
  };

  function automatic logic [16:0] span(input logic [1:0] e);
    logic [16:0] m;
    for (int i = 0; i < 17; i++) m[i] = (i < 9) ? e[0] : e[1];
    return m;
  endfunction

  task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #80000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=%h exp=%h", 17'h0, 17'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    b_en_h = 2'b11; a_en_h = 2'b11;
    ab_tick = 2'b11;
    a_in = 17'h1FFFF;
    repeat (3) step();
    rst = 1'b0;
    step();
    // R11: cleared cells, high tick at release does not capture
    chk("R11 sink after reset", b_sink, 17'h0);
    chk("R11 a_out after reset", a_out, 17'h1FFFF);
    chk("R2 a_drive enabled", {15'h0, a_drive}, {15'h0, 2'b11});

    // enable table, both directions transparent
    ab_pass = 2'b11; ba_pass = 2'b11;
    for (int v = 0; v < 8; v++) begin
      logic [1:0] ben, aen;
      {b_en_h, b_en_l, a_en_h, a_en_l, a_in, ext_low} = VEC[v];
      ben = b_en_h & ~b_en_l;
      aen = a_en_h & ~a_en_l;
      #1;
      chk("R1/R4 b_sink table", b_sink, a_in & span(ben));
      chk("R2 a_drive table", {15'h0, a_drive}, {15'h0, aen});
      chk("R3 a_out table", a_out, (a_in & span(ben)) | ext_low);
      step();
    end

    // directed: capture / hold
    b_en_h = 2'b11; b_en_l = 2'b00; a_en_h = 2'b11; a_en_l = 2'b00;
    ext_low = '0;
    ab_pass = 2'b00; ba_pass = 2'b00;
    ab_tick = 2'b00; ba_tick = 2'b00;
    a_in = 17'h1FFFF;
    step();
    ab_tick = 2'b11;
    step();
    chk("R6 capture on rise", b_sink, 17'h1FFFF);
    a_in = 17'h0F0F0;
    step();
    chk("R7 hold with tick high", b_sink, 17'h1FFFF);
    ab_tick = 2'b00; a_in = 17'h12345;
    step();
    chk("R7 hold with tick low", b_sink, 17'h1FFFF);
    ab_tick = 2'b11;
    step();
    chk("R6 second capture", b_sink, 17'h12345);

    // R9: only narrow section ticks
    ab_tick = 2'b00;
    step();
    a_in = 17'h0AAAA; ab_tick = 2'b10;
    step();
    chk("R9 section independence", b_sink, (17'h0AAAA & 17'h1FE00) | (17'h12345 & 17'h001FF));

    // R5: transparent ignores tick
    ab_pass = 2'b11; ab_tick = 2'b00; a_in = 17'h15555;
    #1;
    chk("R5 transparent same cycle", b_sink, 17'h15555);
    step();
    ab_tick = 2'b11; a_in = 17'h0C3C3;
    step();
    chk("R5 transparent tick ignored", b_sink, 17'h0C3C3);
    // R7: pass drops, value from last edge kept
    ab_pass = 2'b00; a_in = 17'h1F00F;
    #1;
    chk("R7 latch close holds", b_sink, 17'h0C3C3);

    // R8: simultaneous captures in both directions
    ab_tick = 2'b00; ba_tick = 2'b00;
    step();
    a_in = 17'h16969; ext_low = 17'h00F0F;
    ab_tick = 2'b11; ba_tick = 2'b11;
    step();
    chk("R8 A-to-B capture", b_sink, 17'h16969);
    chk("R8 B-to-A sees pre-edge line", a_out, 17'h0C3C3 | 17'h00F0F);
    // disabling B leaves A-side capture result and isolates line
    b_en_l = 2'b01;
    #1;
    chk("R1 wide section isolated", b_sink, 17'h16969 & 17'h1FE00);

    // R10 clock forwarding
    fwd_clk_b = 1'b1;
    #1;
    chk("R10 forward high", {16'h0, fwd_clk_a}, 17'h1);
    fwd_clk_b = 1'b0;
    #1;
    chk("R10 forward low", {16'h0, fwd_clk_a}, 17'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule